// File: doc/BRIEF.md
# ALC Level Detection Front-End

This block is the measuring side of an automatic level control for a mono audio stream. One of two sample streams, the record stream or the playback stream, is chosen by a select input. The chosen sample is clamped so that its magnitude always fits. A first-order zero-pole high-pass section then shapes it. The low-cut corner sits near 100 Hz for the zero and 150 Hz for the pole, which leaves roughly 3.5 dB less gain at low frequencies than in the passband. The magnitude of the shaped signal is compared with a programmable limiter threshold. A separate detector compares the magnitude of the unshaped sample with a fixed clip level just above full scale.

The section's coefficients come from a three-entry table. A two-bit rate code selects the entry, and each entry is designed for one sampling-rate range. The gain-update and volume logic downstream reads the two registered flags. A small state machine follows the master enable. State ST_OFF holds the flags low and the filter history at zero. State ST_RUN processes a sample on every strobe. The transition OFF_TO_RUN is taken when the enable is high, and RUN_TO_OFF is taken when it is low.

Top module: `alc_detect_frontend`

## Requirements
- R1: After reset, lim_flag and clip_flag are 0, the filter history is 0, and the stored rate code is 2'b10.
- R2: With path_rec = 1 the block monitors rec_smp, and with path_rec = 0 it monitors play_smp. The unselected stream has no effect on either flag.
- R3: At any clock edge where alc_on is 0, both flags and the filter history are cleared, and smp_stb is ignored.
- R4: The flags are registered. At an edge where alc_on = 1 and smp_stb = 1, they take the result for the sample present at that edge. At any other edge with alc_on = 1, they hold their value.
- R5: A selected sample equal to -2^(SMP_W-1) is replaced by -(2^(SMP_W-1)-1) before the filter and both detectors.
- R6: clip_flag is set when the magnitude of the clamped, unfiltered sample is strictly greater than CLIP = FS + FS/16 + FS/2048, with FS = 2^(SMP_W-2). This is about +0.53 dB above full scale, and 4458496 for SMP_W = 24.
- R7: The filter computes y = floor((2^22·x − Z·x1 + P·y1) / 2^22). Here x1 and y1 are the clamped input and the output of the previous processed sample. y is saturated to ±(2^(SMP_W+1)−1).
- R8: The coefficients (Z, P) are (3980342, 3877489) for code 00 (12 kHz design), (4085922, 4032786) for code 01 (24 kHz design) and (4139758, 4112752) for code 10 (48 kHz design).
- R9: When coef_wr = 1, codes 00, 01 and 10 are stored at that edge. Code 11 is ignored and the previous code is kept. A code change does not clear the filter history.
- R10: With eq_bypass = 0, lim_flag is |y| > lim_thr. With eq_bypass = 1, lim_flag is |clamped sample| > lim_thr. The filter keeps running while it is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| rec_smp | input | SMP_W | Record-stream sample, two's complement |
| play_smp | input | SMP_W | Playback-stream sample, two's complement |
| path_rec | input | 1 | 1 selects the record stream, 0 selects the playback stream |
| alc_on | input | 1 | Master enable of the detection |
| eq_bypass | input | 1 | 1 makes the limiter compare the unfiltered sample |
| lim_thr | input | SMP_W | Unsigned limiter magnitude threshold |
| coef_wr | input | 1 | Write strobe for the rate code |
| coef_code | input | 2 | Rate code to store |
| lim_flag | output | 1 | Limiter threshold exceeded |
| clip_flag | output | 1 | Clip level exceeded |

## Verification
The bench places samples exactly at the clip level and one step above it. A detector that used >= instead of >, or that read the filtered signal, would flag the wrong one of the pair. It feeds the most negative code with the threshold set one below and exactly at the largest magnitude. A missing clamp would wrap the magnitude or flag at the equal value. It writes the reserved rate code in the middle of a DC step. A design that loaded the code, or cleared the history on a code change, would end the limiter flag's decay at a different sample. It also drops the enable in the middle of a run. A design that kept its history would show a different transient when the enable returns.

// File: rtl/alc_det_pkg.sv
package alc_det_pkg;

    localparam int COEF_W    = 24;
    localparam int COEF_FRAC = 22;

    typedef enum logic [1:0] {
        RATE_12K  = 2'b00,
        RATE_24K  = 2'b01,
        RATE_48K  = 2'b10,
        RATE_RSVD = 2'b11
    } rate_code_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } det_state_e;

    typedef struct packed {
        logic [COEF_W-1:0] zero_c;
        logic [COEF_W-1:0] pole_c;
    } zp_coef_t;

    // zero and pole radii in Q2.22, unity feed-forward gain
    localparam logic [COEF_W-1:0] ZERO_12K = 24'd3980342;
    localparam logic [COEF_W-1:0] POLE_12K = 24'd3877489;
    localparam logic [COEF_W-1:0] ZERO_24K = 24'd4085922;
    localparam logic [COEF_W-1:0] POLE_24K = 24'd4032786;
    localparam logic [COEF_W-1:0] ZERO_48K = 24'd4139758;
    localparam logic [COEF_W-1:0] POLE_48K = 24'd4112752;

endpackage

// File: rtl/alc_coef_bank.sv
module alc_coef_bank
    import alc_det_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        code_in,
    output rate_code_e        code_q,
    output zp_coef_t          coef
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RATE_48K;
        end else if (wr_en && (code_in != RATE_RSVD)) begin
            code_q <= rate_code_e'(code_in);
        end
    end

    always_comb begin
        unique case (code_q)
            RATE_12K: coef = '{zero_c: ZERO_12K, pole_c: POLE_12K};
            RATE_24K: coef = '{zero_c: ZERO_24K, pole_c: POLE_24K};
            RATE_48K: coef = '{zero_c: ZERO_48K, pole_c: POLE_48K};
            default:  coef = '{zero_c: ZERO_48K, pole_c: POLE_48K};
        endcase
    end

endmodule

// File: rtl/alc_zp_filter.sv
module alc_zp_filter
    import alc_det_pkg::*;
#(
    parameter int SMP_W = 24,
    parameter int Y_W   = SMP_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    input  logic signed [SMP_W-1:0] x_in,
    input  zp_coef_t                coef,
    output logic signed [Y_W-1:0]   y_out
);

    localparam int ACC_W = SMP_W + COEF_W + 4;
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((64'sd1 <<< (Y_W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX;

    logic signed [SMP_W-1:0] x1_q;
    logic signed [Y_W-1:0]   y1_q;

    logic signed [ACC_W-1:0] xe, x1e, y1e, ze, pe, acc, yq;

    always_comb begin
        xe  = ACC_W'(x_in);
        x1e = ACC_W'(x1_q);
        y1e = ACC_W'(y1_q);
        ze  = $signed(ACC_W'(coef.zero_c));
        pe  = $signed(ACC_W'(coef.pole_c));
        acc = (xe <<< COEF_FRAC) - (x1e * ze) + (y1e * pe);
        yq  = acc >>> COEF_FRAC;
        if (yq > Y_MAX) begin
            y_out = Y_W'(Y_MAX);
        end else if (yq < Y_MIN) begin
            y_out = Y_W'(Y_MIN);
        end else begin
            y_out = Y_W'(yq);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1_q <= '0;
            y1_q <= '0;
        end else if (clr) begin
            x1_q <= '0;
            y1_q <= '0;
        end else if (adv) begin
            x1_q <= x_in;
            y1_q <= y_out;
        end
    end

endmodule

// File: rtl/alc_mag_cmp.sv
module alc_mag_cmp #(
    parameter int IN_W  = 26,
    parameter int THR_W = 24
) (
    input  logic signed [IN_W-1:0] val,
    input  logic [THR_W-1:0]       thr,
    output logic                   over
);

    localparam int CMP_W = (IN_W > THR_W) ? IN_W : THR_W;
    localparam logic [IN_W-1:0] MOST_NEG = {1'b1, {(IN_W-1){1'b0}}};
    localparam logic [IN_W-1:0] MOST_POS = {1'b0, {(IN_W-1){1'b1}}};

    logic [IN_W-1:0] mag;

    always_comb begin
        if (val == $signed(MOST_NEG)) begin
            mag = MOST_POS;
        end else if (val[IN_W-1]) begin
            mag = IN_W'(-val);
        end else begin
            mag = IN_W'(val);
        end
        over = CMP_W'(mag) > CMP_W'(thr);
    end

endmodule

// File: rtl/alc_detect_frontend.sv
module alc_detect_frontend
    import alc_det_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic signed [SMP_W-1:0] rec_smp,
    input  logic signed [SMP_W-1:0] play_smp,
    input  logic                    path_rec,
    input  logic                    alc_on,
    input  logic                    eq_bypass,
    input  logic [SMP_W-1:0]        lim_thr,
    input  logic                    coef_wr,
    input  logic [1:0]              coef_code,
    output logic                    lim_flag,
    output logic                    clip_flag
);

    localparam int Y_W = SMP_W + 2;
    localparam logic [SMP_W-1:0] FULL_SCALE = SMP_W'(1) << (SMP_W - 2);
    localparam logic [SMP_W-1:0] CLIP_LVL   = FULL_SCALE + (FULL_SCALE >> 4) + (FULL_SCALE >> 11);
    localparam logic signed [SMP_W-1:0] X_MIN = {1'b1, {(SMP_W-1){1'b0}}};

    det_state_e st_q, st_d;
    rate_code_e coef_code_q;
    zp_coef_t   coef;

    logic signed [SMP_W-1:0] x_sel, x_sat;
    logic signed [Y_W-1:0]   y_now, lim_src;
    logic                    hist_clr, hist_adv;
    logic                    over_lim, over_clip;

    // stream selection and clamp of the single unrepresentable magnitude
    always_comb begin
        x_sel = path_rec ? rec_smp : play_smp;
        x_sat = (x_sel == X_MIN) ? (X_MIN + SMP_W'(1)) : x_sel;
    end

    // state register
    always_comb begin
        st_d = alc_on ? ST_RUN : ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // per-state controls for the filter history
    always_comb begin
        hist_clr = 1'b0;
        hist_adv = 1'b0;
        unique case (st_d)
            ST_OFF: hist_clr = 1'b1;
            ST_RUN: hist_adv = smp_stb;
        endcase
    end

    // registered flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_flag  <= 1'b0;
            clip_flag <= 1'b0;
        end else begin
            unique case (st_d)
                ST_OFF: begin
                    lim_flag  <= 1'b0;
                    clip_flag <= 1'b0;
                end
                ST_RUN: begin
                    if (smp_stb) begin
                        lim_flag  <= over_lim;
                        clip_flag <= over_clip;
                    end
                end
            endcase
        end
    end

    alc_coef_bank u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (coef_wr),
        .code_in (coef_code),
        .code_q  (coef_code_q),
        .coef    (coef)
    );

    alc_zp_filter #(.SMP_W(SMP_W), .Y_W(Y_W)) u_eq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hist_clr),
        .adv   (hist_adv),
        .x_in  (x_sat),
        .coef  (coef),
        .y_out (y_now)
    );

    always_comb begin
        lim_src = eq_bypass ? Y_W'(x_sat) : y_now;
    end

    alc_mag_cmp #(.IN_W(Y_W), .THR_W(SMP_W)) u_lim_det (
        .val  (lim_src),
        .thr  (lim_thr),
        .over (over_lim)
    );

    alc_mag_cmp #(.IN_W(SMP_W), .THR_W(SMP_W)) u_clip_det (
        .val  (x_sat),
        .thr  (CLIP_LVL),
        .over (over_clip)
    );

endmodule

// File: rtl/alc_detect_chk.sv
module alc_detect_chk #(
    parameter int SMP_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_stb,
    input logic signed [SMP_W-1:0] rec_smp,
    input logic signed [SMP_W-1:0] play_smp,
    input logic                    path_rec,
    input logic                    alc_on,
    input logic                    eq_bypass,
    input logic [SMP_W-1:0]        lim_thr,
    input logic                    coef_wr,
    input logic [1:0]              coef_code,
    input logic                    lim_flag,
    input logic                    clip_flag,
    input logic [1:0]              coef_code_q
);

    localparam logic [SMP_W-1:0] FS   = SMP_W'(1) << (SMP_W - 2);
    localparam logic [SMP_W-1:0] CLIP = FS + (FS >> 4) + (FS >> 11);

    logic signed [SMP_W-1:0] pick;
    logic [SMP_W-1:0]        mag_in;

    always_comb begin
        pick = path_rec ? rec_smp : play_smp;
        if (pick[SMP_W-1]) begin
            mag_in = (pick == {1'b1, {(SMP_W-1){1'b0}}}) ? {1'b0, {(SMP_W-1){1'b1}}} : SMP_W'(-pick);
        end else begin
            mag_in = SMP_W'(pick);
        end
    end

    // R3
    off_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_on |=> (!lim_flag && !clip_flag));

    // R4
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_on && !smp_stb) |=> ($stable(lim_flag) && $stable(clip_flag)));

    // R9
    rsvd_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_wr && coef_code == 2'b11) |=> $stable(coef_code_q));

    // R9
    code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_wr && coef_code != 2'b11) |=> (coef_code_q == $past(coef_code)));

    // R6
    clip_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_on && smp_stb && (mag_in > CLIP)) |=> clip_flag);

    // R6
    clip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_on && smp_stb && (mag_in <= CLIP)) |=> !clip_flag);

    // R10
    bypass_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alc_on && smp_stb && eq_bypass) |=> (lim_flag == $past(mag_in > lim_thr)));

    // R1
    always @(posedge clk) begin
        if (rst_n) begin
            code_legal_chk: assert (coef_code_q != 2'b11);
        end
    end

endmodule

bind alc_detect_frontend alc_detect_chk #(.SMP_W(SMP_W)) u_chk (.*);

// File: tb/test_alc_detect_frontend.sv
module test_alc_detect_frontend;

    localparam int  CLK_PERIOD = 10;
    localparam int  W     = 24;
    localparam longint FS    = 64'd4194304;
    localparam longint CLIPM = FS + FS / 16 + FS / 2048;
    localparam longint YMAX  = (64'sd1 <<< (W + 1)) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic signed [W-1:0] rec_smp = '0;
    logic signed [W-1:0] play_smp = '0;
    logic path_rec = 1'b1;
    logic alc_on = 1'b0;
    logic eq_bypass = 1'b0;
    logic [W-1:0] lim_thr = '0;
    logic coef_wr = 1'b0;
    logic [1:0] coef_code = 2'b00;
    logic lim_flag, clip_flag;

    int checks = 0;
    int errors = 0;

    longint x1_m = 0, y1_m = 0;
    int     code_m = 2;
    bit     lim_m = 1'b0, clip_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alc_detect_frontend #(.SMP_W(W)) i_alc_detect_frontend (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .rec_smp(rec_smp),
        .play_smp(play_smp), .path_rec(path_rec), .alc_on(alc_on),
        .eq_bypass(eq_bypass), .lim_thr(lim_thr), .coef_wr(coef_wr),
        .coef_code(coef_code), .lim_flag(lim_flag), .clip_flag(clip_flag)
    );

    function automatic longint absl(input longint v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check_flags(input string tag);
        checks++;
        if (lim_flag !== lim_m) begin
            errors++;
            $display("FAIL %s lim_flag actual %b expected %b at %0t", tag, lim_flag, lim_m, $time);
        end
        checks++;
        if (clip_flag !== clip_m) begin
            errors++;
            $display("FAIL %s clip_flag actual %b expected %b at %0t", tag, clip_flag, clip_m, $time);
        end
    endtask

    // advance one clock, update the behavioural reference, compare after the edge
    task automatic tick(input string tag);
        longint xs, zc, pc, acc, y;
        @(posedge clk);
        if (rst_n) begin
            xs = path_rec ? longint'(rec_smp) : longint'(play_smp);
            if (xs == -8388608) xs = -8388607;
            case (code_m)
                0: begin zc = 3980342; pc = 3877489; end
                1: begin zc = 4085922; pc = 4032786; end
                default: begin zc = 4139758; pc = 4112752; end
            endcase
            if (!alc_on) begin
                lim_m = 0; clip_m = 0; x1_m = 0; y1_m = 0;
            end else if (smp_stb) begin
                acc = xs * 4194304 - x1_m * zc + y1_m * pc;
                y = acc >>> 22;
                if (y > YMAX) y = YMAX;
                if (y < -YMAX) y = -YMAX;
                clip_m = absl(xs) > CLIPM;
                lim_m = eq_bypass ? (absl(xs) > longint'(lim_thr)) : (absl(y) > longint'(lim_thr));
                x1_m = xs; y1_m = y;
            end
            if (coef_wr && coef_code != 2'b11) code_m = int'(coef_code);
        end
        #1;
        check_flags(tag);
    endtask

    task automatic strobe(input string tag, input logic signed [W-1:0] s);
        rec_smp = s; play_smp = s; smp_stb = 1'b1;
        tick(tag);
        smp_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1 check_flags("R1 reset");

        // R3: disabled block ignores full-scale strobes
        alc_on = 0; lim_thr = 0;
        for (int i = 0; i < 4; i++) strobe("R3 off", 24'sh7FFFFF);

        // R6: clip boundary on unfiltered path
        alc_on = 1; path_rec = 1; lim_thr = 24'hFFFFFF;
        tick("R3 enable");
        strobe("R6 at level", W'(CLIPM));
        strobe("R6 above level", W'(CLIPM + 1));
        strobe("R6 negative above", W'(-(CLIPM + 1)));
        strobe("R4 after strobe", 24'sd0);
        tick("R4 hold");

        // R2: unselected stream has no effect
        rec_smp = 24'sd1000; play_smp = 24'sh7FFFFF; smp_stb = 1; tick("R2 rec selected"); smp_stb = 0;
        path_rec = 0; smp_stb = 1; tick("R2 play selected"); smp_stb = 0;
        path_rec = 1;

        // R5 and R10: most negative code with bypassed filter
        eq_bypass = 1; lim_thr = 24'd8388606;
        strobe("R5 thr below", 24'sh800000);
        lim_thr = 24'd8388607;
        strobe("R5 thr equal", 24'sh800000);
        strobe("R10 bypass small", 24'sd100);

        // R7/R8: DC step decay for each design rate
        eq_bypass = 0; lim_thr = 24'd3000000;
        for (int c = 0; c < 3; c++) begin
            alc_on = 0; tick("R3 clear"); alc_on = 1;
            coef_wr = 1; coef_code = 2'(c); tick("R9 load"); coef_wr = 0;
            for (int i = 0; i < 80; i++) strobe("R8 dc step", 24'sd4000000);
        end

        // R9: reserved code written mid-step is ignored, history kept
        alc_on = 0; tick("R3 clear"); alc_on = 1;
        coef_wr = 1; coef_code = 2'b00; tick("R9 load"); coef_wr = 0;
        for (int i = 0; i < 10; i++) strobe("R9 before", 24'sd4000000);
        coef_wr = 1; coef_code = 2'b11; smp_stb = 1; rec_smp = 24'sd4000000; tick("R9 reserved"); coef_wr = 0; smp_stb = 0;
        for (int i = 0; i < 40; i++) strobe("R9 after", 24'sd4000000);
        coef_wr = 1; coef_code = 2'b01; tick("R9 switch"); coef_wr = 0;
        for (int i = 0; i < 40; i++) strobe("R9 no clear", 24'sd4000000);

        // R7: random streams and controls
        for (int i = 0; i < 4000; i++) begin
            smp_stb   = ($urandom_range(0, 3) != 0);
            rec_smp   = W'($urandom);
            play_smp  = W'($urandom);
            path_rec  = $urandom_range(0, 1) == 1;
            alc_on    = ($urandom_range(0, 19) != 0);
            eq_bypass = ($urandom_range(0, 4) == 0);
            lim_thr   = W'($urandom_range(0, 9000000));
            coef_wr   = ($urandom_range(0, 49) == 0);
            coef_code = 2'($urandom);
            tick("R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule